// File: doc/BRIEF.md
# Register bank address decoder

This block is the address decoder for a memory-mapped bank of registers. It is purely combinational. The write side takes a word-aligned write address and raises one select strobe for the register word being written, together with a flag saying whether the write is accepted. The read side takes a separate read address and returns the addressed word together with a read-valid flag. The register flops themselves live outside the block: their contents come in on `reg_val`, and the strobes go back out to them.

A register may be wider than the bus word. It then occupies several consecutive word addresses, and each address exposes one equal slice of the register, zero-extended to the bus width. The bank can sit inside a larger address area. An optional area-tag compare on the upper address bits gates the whole decode. A read that hits no register word is passed on to a secondary read path (`alt_rd_data` / `alt_rd_ok`), so banks can be chained.

Registers come in three kinds: plain, write-only, and muxed. A muxed register shows one of several copies, and it takes its valid flag from the selector of that copy (`sel_ok`). There is no data stream at the block's edge, so there is no valid/ready handshake and no back-pressure: every pin is a plain control or data level, and the outputs settle within the same cycle.

Top module: `regbank_decode`

## Requirements
- R1: Only address bits [AREA_BITS-1:WORD_OFF] (bits [5:2] by default) select a word inside the bank; the byte-offset bits [1:0] have no effect on any output.
- R2: Each register word owns one bit of `wr_sel`, packed in register order (default: reg0 word0 = bit 0, reg1 words 0..1 = bits 1..2, reg2 = bit 3, reg3 words 0..1 = bits 4..5). Only the bit of the matched write word is 1; all others are 0.
- R3: `rd_sel` uses the same bit layout. It is 1 only at the matched read word of a readable register, and it is all-zero otherwise.
- R4: Word i of a register of width W spanning N words (default bases 0, 2, 5, 6; N 1, 2, 1, 2; W 32, 48, 16, 64) reads bits [i*W/N +: W/N]. Upper bits beyond the slice read as 0.
- R5: A write address that matches no register word gives `wr_ok` = 0 and an all-zero `wr_sel`.
- R6: A read address that matches no register word forwards `alt_rd_data` and `alt_rd_ok` unchanged to `rd_data` and `rd_ok`.
- R7: A write-only register (default reg2) reads as all-zero with `rd_ok` = 0 and no read strobe. Writes to it are accepted.
- R8: When the area check is on and address bits [ADDR_W-1:AREA_BITS] differ from AREA_TAG (default 5, so the bank spans 0x140..0x17F), nothing matches. The write is then not accepted and the read falls through to the secondary path.
- R9: A muxed register (default reg3) reports `sel_ok` for its index as both `rd_ok` and `wr_ok`. All other readable registers report 1 for reads, and all writable registers report 1 for writes. The strobes and data are the same either way.
- R10: The outputs follow changes of `reg_val` and the addresses with no clock edge in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_addr | input | ADDR_W | Byte address of the current write |
| rd_addr | input | ADDR_W | Byte address of the current read |
| reg_val | input | NREG*MAXW | Register contents, MAXW bits per register, register 0 in the low slot |
| sel_ok | input | NREG | Selector-valid flag per register (used only by muxed registers) |
| alt_rd_data | input | WORD_BITS | Read data from the secondary path |
| alt_rd_ok | input | 1 | Read-valid from the secondary path |
| wr_sel | output | NSTROBE | One-hot write strobe per register word |
| wr_ok | output | 1 | Write accepted |
| rd_sel | output | NSTROBE | One-hot read strobe per register word |
| rd_data | output | WORD_BITS | Read data |
| rd_ok | output | 1 | Read valid |

## Verification
The bench aims at the split of wide registers. It reads both halves of the 48-bit and the 64-bit register: a decoder with the slice stride or the zero-extension wrong would return shifted data or stray upper bits. It checks that the gap words, the words past the last register, and addresses with a wrong area tag all fall through to the secondary path. A decoder that returned zero there, or that ignored the tag, would break chaining. It also reads the write-only register and clears a muxed register's selector flag. These catch a design that acknowledges write-only reads, or one that hard-wires the valid flag to 1.

// File: rtl/regbank_pkg.sv
package regbank_pkg;
  typedef enum logic [1:0] {
    REG_RW  = 2'd0,
    REG_WO  = 2'd1,
    REG_MUX = 2'd2
  } reg_kind_e;
endpackage

// File: rtl/regbank_area_gate.sv
module regbank_area_gate #(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned WORD_OFF  = 2,
  parameter int unsigned AREA_BITS = 6,
  parameter bit          CHECK     = 1'b1,
  parameter logic [ADDR_W-AREA_BITS-1:0] TAG = '0,
  localparam int unsigned OFF_W = AREA_BITS - WORD_OFF
) (
  input  logic [ADDR_W-1:0] addr,
  output logic              hit,
  output logic [OFF_W-1:0]  off
);
  logic unused_byte;
  assign unused_byte = ^addr[WORD_OFF-1:0];
  assign off = addr[AREA_BITS-1:WORD_OFF];

  generate
    if (CHECK) begin : g_check
      assign hit = (addr[ADDR_W-1:AREA_BITS] == TAG);
    end else begin : g_open
      logic unused_upper;
      assign unused_upper = ^addr[ADDR_W-1:AREA_BITS];
      assign hit = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/regbank_reg_slot.sv
module regbank_reg_slot
  import regbank_pkg::*;
#(
  parameter int unsigned OFF_W     = 4,
  parameter int unsigned BASE      = 0,
  parameter int unsigned NW        = 1,
  parameter int unsigned WIDTH     = 32,
  parameter int unsigned MAXW      = 64,
  parameter int unsigned WORD_BITS = 32,
  parameter reg_kind_e   KIND      = REG_RW,
  localparam int unsigned SW = WIDTH / NW
) (
  input  logic [OFF_W-1:0]     wr_off,
  input  logic                 wr_area,
  input  logic [OFF_W-1:0]     rd_off,
  input  logic                 rd_area,
  input  logic [MAXW-1:0]      content,
  input  logic                 sel_ok,
  output logic [NW-1:0]        wr_hit,
  output logic [NW-1:0]        rd_hit,
  output logic                 rd_match,
  output logic [WORD_BITS-1:0] rd_word,
  output logic                 rd_valid,
  output logic                 wr_acc
);
  logic [NW-1:0] rd_addr_hit;
  logic          ok_flag;

  generate
    for (genvar i = 0; i < NW; i++) begin : g_word
      assign wr_hit[i]      = wr_area && (wr_off == OFF_W'(BASE + i));
      assign rd_addr_hit[i] = rd_area && (rd_off == OFF_W'(BASE + i));
    end

    if (KIND == REG_MUX) begin : g_mux_ok
      assign ok_flag = sel_ok;
    end else begin : g_fixed_ok
      logic unused_sel;
      assign unused_sel = sel_ok;
      assign ok_flag = 1'b1;
    end

    if (WIDTH < MAXW) begin : g_spare
      logic unused_hi;
      assign unused_hi = ^content[MAXW-1:WIDTH];
    end
  endgenerate

  assign rd_match = |rd_addr_hit;
  assign wr_acc   = (|wr_hit) && ok_flag;

  generate
    if (KIND == REG_WO) begin : g_wo
      logic unused_lo;
      assign unused_lo = ^content[WIDTH-1:0];
      assign rd_hit   = '0;
      assign rd_word  = '0;
      assign rd_valid = 1'b0;
    end else begin : g_rd
      assign rd_hit   = rd_addr_hit;
      assign rd_valid = ok_flag;
      always_comb begin
        rd_word = '0;
        for (int i = 0; i < NW; i++) begin
          if (rd_addr_hit[i]) rd_word[SW-1:0] = content[i*SW +: SW];
        end
      end
    end
  endgenerate

  always_comb begin
    assert_wo_silent_R7: assert (KIND != REG_WO || (rd_valid == 1'b0 && rd_word == '0 && rd_hit == '0));
    assert_slice_zext_R4: assert (SW >= WORD_BITS || rd_word[WORD_BITS-1:SW] == '0);
    assert_no_area_no_wr_R8: assert (wr_area || wr_hit == '0);
  end
endmodule

// File: rtl/regbank_decode.sv
module regbank_decode
  import regbank_pkg::*;
#(
  parameter int unsigned ADDR_W    = 12,
  parameter int unsigned WORD_OFF  = 2,
  parameter int unsigned AREA_BITS = 6,
  parameter int unsigned WORD_BITS = 32,
  parameter int unsigned MAXW      = 64,
  parameter bit          AREA_CHECK = 1'b1,
  parameter logic [ADDR_W-AREA_BITS-1:0] AREA_TAG = 6'd5,
  parameter int unsigned NREG      = 4,
  parameter int unsigned NSTROBE   = 6,
  parameter int unsigned REG_BASE  [NREG] = '{0, 2, 5, 6},
  parameter int unsigned REG_NW    [NREG] = '{1, 2, 1, 2},
  parameter int unsigned REG_WIDTH [NREG] = '{32, 48, 16, 64},
  parameter reg_kind_e   REG_KIND  [NREG] = '{REG_RW, REG_RW, REG_WO, REG_MUX},
  localparam int unsigned OFF_W = AREA_BITS - WORD_OFF
) (
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [ADDR_W-1:0]      rd_addr,
  input  logic [NREG*MAXW-1:0]   reg_val,
  input  logic [NREG-1:0]        sel_ok,
  input  logic [WORD_BITS-1:0]   alt_rd_data,
  input  logic                   alt_rd_ok,
  output logic [NSTROBE-1:0]     wr_sel,
  output logic                   wr_ok,
  output logic [NSTROBE-1:0]     rd_sel,
  output logic [WORD_BITS-1:0]   rd_data,
  output logic                   rd_ok
);
  function automatic int unsigned first_word(input int unsigned idx);
    int unsigned acc = 0;
    for (int k = 0; k < NREG; k++) if (k < idx) acc += REG_NW[k];
    return acc;
  endfunction

  logic             wr_area, rd_area;
  logic [OFF_W-1:0] wr_off, rd_off;

  regbank_area_gate #(
    .ADDR_W(ADDR_W), .WORD_OFF(WORD_OFF), .AREA_BITS(AREA_BITS),
    .CHECK(AREA_CHECK), .TAG(AREA_TAG)
  ) u_wr_gate (.addr(wr_addr), .hit(wr_area), .off(wr_off));

  regbank_area_gate #(
    .ADDR_W(ADDR_W), .WORD_OFF(WORD_OFF), .AREA_BITS(AREA_BITS),
    .CHECK(AREA_CHECK), .TAG(AREA_TAG)
  ) u_rd_gate (.addr(rd_addr), .hit(rd_area), .off(rd_off));

  logic [NREG-1:0]      slot_rd_match, slot_rd_valid, slot_wr_acc;
  logic [WORD_BITS-1:0] slot_rd_word [NREG];

  generate
    for (genvar g = 0; g < NREG; g++) begin : g_reg
      localparam int unsigned FIRST = first_word(g);
      localparam int unsigned NW    = REG_NW[g];
      logic [NW-1:0] wh, rh;

      regbank_reg_slot #(
        .OFF_W(OFF_W), .BASE(REG_BASE[g]), .NW(NW), .WIDTH(REG_WIDTH[g]),
        .MAXW(MAXW), .WORD_BITS(WORD_BITS), .KIND(REG_KIND[g])
      ) u_slot (
        .wr_off(wr_off), .wr_area(wr_area),
        .rd_off(rd_off), .rd_area(rd_area),
        .content(reg_val[g*MAXW +: MAXW]),
        .sel_ok(sel_ok[g]),
        .wr_hit(wh), .rd_hit(rh),
        .rd_match(slot_rd_match[g]),
        .rd_word(slot_rd_word[g]),
        .rd_valid(slot_rd_valid[g]),
        .wr_acc(slot_wr_acc[g])
      );

      assign wr_sel[FIRST +: NW] = wh;
      assign rd_sel[FIRST +: NW] = rh;
    end
  endgenerate

  always_comb begin
    rd_data = alt_rd_data;
    rd_ok   = alt_rd_ok;
    for (int g = 0; g < NREG; g++) begin
      if (slot_rd_match[g]) begin
        rd_data = slot_rd_word[g];
        rd_ok   = slot_rd_valid[g];
      end
    end
  end

  assign wr_ok = |slot_wr_acc;

  always_comb begin
    assert_wr_onehot_R2: assert ($onehot0(wr_sel));
    assert_rd_onehot_R3: assert ($onehot0(rd_sel));
    assert_wr_ok_needs_strobe_R5: assert (!wr_ok || wr_sel != '0);
    assert_miss_forward_R6: assert (slot_rd_match != '0 || (rd_data == alt_rd_data && rd_ok == alt_rd_ok));
    assert_outside_area_R8: assert (rd_area || rd_sel == '0);
    assert_single_match_R1: assert ($onehot0(slot_rd_match));
  end
endmodule

// File: tb/regbank_decode_bench.sv
module regbank_decode_bench;
  import regbank_pkg::*;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic [11:0]  wr_addr, rd_addr;
  logic [255:0] reg_val;
  logic [3:0]   sel_ok;
  logic [31:0]  alt_rd_data;
  logic         alt_rd_ok;
  logic [5:0]   wr_sel, rd_sel;
  logic         wr_ok, rd_ok;
  logic [31:0]  rd_data;

  regbank_decode u_regbank_decode (
    .wr_addr(wr_addr), .rd_addr(rd_addr), .reg_val(reg_val), .sel_ok(sel_ok),
    .alt_rd_data(alt_rd_data), .alt_rd_ok(alt_rd_ok),
    .wr_sel(wr_sel), .wr_ok(wr_ok), .rd_sel(rd_sel), .rd_data(rd_data), .rd_ok(rd_ok)
  );

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [11:0] wa;
    logic [11:0] ra;
    logic [5:0]  ews;
    logic        ewok;
    logic [5:0]  ers;
    logic [31:0] erd;
    logic        erok;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{12'h140, 12'h140, 6'b000001, 1'b1, 6'b000001, 32'hA5A5_0001, 1'b1, 8'd2},
    '{12'h148, 12'h14C, 6'b000010, 1'b1, 6'b000100, 32'h0012_3456, 1'b1, 8'd4},
    '{12'h154, 12'h154, 6'b001000, 1'b1, 6'b000000, 32'h0000_0000, 1'b0, 8'd7},
    '{12'h158, 12'h15C, 6'b010000, 1'b1, 6'b100000, 32'hCAFE_F00D, 1'b1, 8'd4},
    '{12'h143, 12'h14A, 6'b000001, 1'b1, 6'b000010, 32'h0078_9ABC, 1'b1, 8'd1},
    '{12'h144, 12'h144, 6'b000000, 1'b0, 6'b000000, 32'h5EC0_0001, 1'b1, 8'd5},
    '{12'h17C, 12'h17C, 6'b000000, 1'b0, 6'b000000, 32'h5EC0_0001, 1'b1, 8'd6},
    '{12'h040, 12'h040, 6'b000000, 1'b0, 6'b000000, 32'h5EC0_0001, 1'b1, 8'd8},
    '{12'h540, 12'h558, 6'b000000, 1'b0, 6'b000000, 32'h5EC0_0001, 1'b1, 8'd8},
    '{12'h15C, 12'h158, 6'b100000, 1'b1, 6'b010000, 32'h0BAD_D00D, 1'b1, 8'd3}
  };

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apply(input logic [11:0] wa, input logic [11:0] ra);
    @(negedge clk);
    wr_addr = wa;
    rd_addr = ra;
    #1;
  endtask

  task automatic check_all(input string req, input logic [5:0] ews, input logic ewok,
                           input logic [5:0] ers, input logic [31:0] erd, input logic erok);
    check(req, "wr_sel",  32'(wr_sel),  32'(ews));
    check(req, "wr_ok",   32'(wr_ok),   32'(ewok));
    check(req, "rd_sel",  32'(rd_sel),  32'(ers));
    check(req, "rd_data", rd_data,      erd);
    check(req, "rd_ok",   32'(rd_ok),   32'(erok));
  endtask

  initial begin
    wr_addr = '0;
    rd_addr = '0;
    sel_ok = 4'b1111;
    alt_rd_data = 32'h5EC0_0001;
    alt_rd_ok = 1'b1;
    reg_val = '0;
    reg_val[0*64 +: 64] = 64'h0000_0000_A5A5_0001;
    reg_val[1*64 +: 64] = 64'h0000_1234_5678_9ABC;
    reg_val[2*64 +: 64] = 64'h0000_0000_0000_BEEF;
    reg_val[3*64 +: 64] = 64'hCAFE_F00D_0BAD_D00D;

    // Idle state: both addresses outside the bank (R5, R6, R8)
    #1;
    check_all("R8", 6'b0, 1'b0, 6'b0, 32'h5EC0_0001, 1'b1);

    for (int v = 0; v < NV; v++) begin
      apply(VECS[v].wa, VECS[v].ra);
      check_all($sformatf("R%0d", VECS[v].req), VECS[v].ews, VECS[v].ewok,
                VECS[v].ers, VECS[v].erd, VECS[v].erok);
    end

    // R9: muxed register follows its selector flag for read and write
    sel_ok[3] = 1'b0;
    apply(12'h158, 12'h158);
    check_all("R9", 6'b010000, 1'b0, 6'b010000, 32'h0BAD_D00D, 1'b0);
    // R9: clearing the muxed flag does not touch plain registers
    apply(12'h14C, 12'h140);
    check_all("R9", 6'b000100, 1'b1, 6'b000001, 32'hA5A5_0001, 1'b1);
    sel_ok[3] = 1'b1;

    // R6: a miss forwards an invalid secondary response as well
    alt_rd_ok = 1'b0;
    alt_rd_data = 32'h0000_7777;
    apply(12'h150, 12'h150);
    check_all("R6", 6'b0, 1'b0, 6'b0, 32'h0000_7777, 1'b0);
    alt_rd_ok = 1'b1;

    // R10: content change is visible with no clock edge
    apply(12'h000, 12'h148);
    reg_val[1*64 +: 64] = 64'h0000_0000_00FF_FFFF;
    #1;
    check("R10", "rd_data", rd_data, 32'h00FF_FFFF);
    // R4: upper slice of a 48-bit register is zero-extended
    rd_addr = 12'h14F;
    #1;
    check("R4", "rd_data", rd_data, 32'h0000_0000);

    // R7: write-only register reads zero even with byte offset set
    apply(12'h157, 12'h156);
    check_all("R7", 6'b001000, 1'b1, 6'b0, 32'h0, 1'b0);

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #200000;
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule